// File: doc/BRIEF.md
# Eight-Point Distributed-Arithmetic Cosine Transform

This block computes a one-dimensional eight-point discrete cosine transform. It accepts one vector of eight signed samples per clock and returns the eight transform coefficients three clock edges later. It uses no multipliers and no coefficient lookup memories. Each output is an inner product of the input with fixed cosine weights, and it is evaluated by distributed arithmetic. For every bit position of the quantized weights, the inputs whose weight has that bit set are summed into one word. The nine words are then shifted and added in a single parallel tree.

The tree splits every shifted word into an integer part and a fractional part. The integer parts are summed exactly. Only the top fractional columns are summed exactly, and the remaining low columns are replaced by a constant that is their expected value. Rounding that compensated fraction gives the bias added to the integer sum. The result is nearly as accurate as a full-width sum, and it carries no systematic bias.

A first stage folds the vector into four mirror sums and four mirror differences. The even-indexed outputs are built from the sums and the odd-indexed outputs from the differences, so each inner product has four terms. The block is meant as the row or column engine of a larger two-dimensional transform.

Top module: `dct8_da`

## Requirements
- R1: Sample m is read from in_x bits [9m+8:9m], and output n is driven on out_z bits [12n+11:12n], both in two's complement. Every output Z_n lies within 2 LSB of round(0.5·k_n·Σ_m x_m·cos((2m+1)nπ/16)), where k_0 = 1/√2 and k_n = 1 otherwise. The weights are 9-bit two's-complement fractions of 1/512 with magnitudes 251, 237, 213, 181, 142, 98 and 50 (181 also for n = 0).
- R2: An all-zero input vector yields exactly zero on all eight outputs, so the compensation bias introduces no offset.
- R3: A mirror-symmetric input (x_m = x_{7-m}) gives exactly zero on the four odd outputs. A mirror-antisymmetric input (x_m = −x_{7-m}) gives exactly zero on the four even outputs.
- R4: Over many uniformly random vectors, the mean signed error against the exact real transform stays within ±0.25 LSB (no truncation bias).
- R5: A vector accepted on a clock edge with in_valid high appears with out_valid high after exactly three edges. out_valid is never high without such a vector.
- R6: Outputs are clamped to the signed 12-bit range rather than wrapped. Extreme inputs built from +255 and −256 give results within the R1 tolerance.
- R7: While out_valid is low, out_z keeps the last result. Input data offered with in_valid low has no effect.
- R8: After synchronous reset, out_valid is low and every output is zero.
- R9: Vectors offered on consecutive cycles each produce a result on consecutive cycles, in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input vector is valid this cycle |
| in_x | input | 72 | Eight signed 9-bit samples, sample m at bits [9m+8:9m] |
| out_valid | output | 1 | Output vector is valid this cycle |
| out_z | output | 96 | Eight signed 12-bit coefficients, Z_n at bits [12n+11:12n] |

## Verification
The hardest behaviour to show from the ports is that the compensated tree carries no systematic bias. Any single vector can be within the 2 LSB window even when a truncating tree is used, so one-vector checks cannot reveal it. The bench therefore streams several thousand uniformly random vectors back to back and accumulates the signed error of every output against a double-precision model. It then checks the mean as well as each individual error. Mirror-symmetric, antisymmetric and zero vectors complement this: they force whole halves of the outputs to an exact zero that any stray bias would disturb.

// File: rtl/dct8_pkg.sv
// Shared constants and coefficient generation for the eight-point
// distributed-arithmetic transform. Coefficients are computed, not tabulated
// per row: a small magnitude table indexed by the folded cosine angle.
package dct8_pkg;

    localparam int NPTS   = 8;          // transform length
    localparam int HALF   = NPTS / 2;   // inner-product length after folding
    localparam int COEF_W = 9;          // weight precision, fraction of 1/512

    // Magnitude of 0.5*k*cos(a*pi/16) scaled by 2**COEF_W; a==0 only for row 0,
    // where the 1/sqrt(2) factor is folded in.
    function automatic int cos_mag(input int a);
        case (a)
            0:       return 181;
            1:       return 251;
            2:       return 237;
            3:       return 213;
            4:       return 181;
            5:       return 142;
            6:       return 98;
            7:       return 50;
            default: return 0;
        endcase
    endfunction

    // Signed weight of folded sample m in output row n.
    function automatic logic signed [COEF_W-1:0] dct_coef(input int n, input int m);
        int  a;
        logic neg;
        a   = ((2 * m + 1) * n) % 32;
        if (a > 16) a = 32 - a;
        neg = 1'b0;
        if (a > 8) begin
            a   = 16 - a;
            neg = 1'b1;
        end
        return neg ? COEF_W'(-cos_mag(a)) : COEF_W'(cos_mag(a));
    endfunction

    // All four weights of row n packed, term m at [m*COEF_W +: COEF_W].
    function automatic logic [HALF*COEF_W-1:0] row_coefs(input int n);
        logic [HALF*COEF_W-1:0] r;
        r = '0;
        for (int m = 0; m < HALF; m++) r[m*COEF_W +: COEF_W] = dct_coef(n, m);
        return r;
    endfunction

endpackage

// File: rtl/dct8_butterfly.sv
// Folding stage: registers the mirror sums x[m]+x[N-1-m] and mirror
// differences x[m]-x[N-1-m]. Assumes two's-complement samples; output is one
// bit wider so neither sum nor difference can overflow. Loads only when en.
module dct8_butterfly #(
    parameter int NPTS = 8,
    parameter int SW   = 9
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en,
    input  logic [NPTS*SW-1:0]            x,
    output logic [(NPTS/2)*(SW+1)-1:0]    sum_q,
    output logic [(NPTS/2)*(SW+1)-1:0]    dif_q
);
    localparam int HALF = NPTS / 2;
    localparam int BW   = SW + 1;

    logic [HALF*BW-1:0] sum_d, dif_d;

    // Form the sign-extended mirror sums and differences.
    always_comb begin
        for (int m = 0; m < HALF; m++) begin
            sum_d[m*BW +: BW] = BW'($signed(x[m*SW +: SW])) + BW'($signed(x[(NPTS-1-m)*SW +: SW]));
            dif_d[m*BW +: BW] = BW'($signed(x[m*SW +: SW])) - BW'($signed(x[(NPTS-1-m)*SW +: SW]));
        end
    end

    // Capture the folded vector when a valid input arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            dif_q <= '0;
        end else if (en) begin
            sum_q <= sum_d;
            dif_q <= dif_d;
        end
    end

    // R3: a sum and a difference of the same pair always share parity.
    for (genvar m = 0; m < HALF; m++) begin : g_par
        a_r3_fold_parity: assert property (@(posedge clk) disable iff (!rst_n)
            sum_q[m*BW] == dif_q[m*BW]);
    end

endmodule

// File: rtl/dct8_ecat.sv
// One inner product by distributed arithmetic through an error-compensated
// adder tree. Bit j of the constant weights selects which inputs form word j;
// the nine words are shifted and added in parallel (the sign word subtracted).
// Each shifted word is split at the binary point: integer parts are summed
// exactly; the top MAJOR_COLS fractional columns are summed exactly; the lower
// columns are replaced by their expected value. The rounded fraction is the
// bias added to the integer sum. Stage 1 (en_tree) registers the tree, stage 2
// (en_out) adds the bias and clamps. Assumes COEFS are COEF_W-bit fractions.
module dct8_ecat #(
    parameter int                       NT         = 4,
    parameter int                       IN_W       = 10,
    parameter int                       COEF_W     = 9,
    parameter int                       OUT_W      = 12,
    parameter int                       MAJOR_COLS = 3,
    parameter logic [NT*COEF_W-1:0]     COEFS      = '0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_tree,
    input  logic                en_out,
    input  logic [NT*IN_W-1:0]  v,
    output logic [OUT_W-1:0]    z
);
    localparam int FRAC   = COEF_W;
    localparam int WORD_W = IN_W + $clog2(NT);
    localparam int TERM_W = WORD_W + COEF_W + 1;
    localparam int HIGH_W = TERM_W - FRAC;
    localparam int MP_W   = HIGH_W + $clog2(COEF_W);
    localparam int MAJ_W  = $clog2(COEF_W * (2 ** MAJOR_COLS)) + 1;
    localparam int NUM_W  = MAJ_W + FRAC + 2;
    localparam int LOW_TOP = FRAC - MAJOR_COLS;   // first exactly summed column

    // Twice the expected value of all estimated low columns.
    function automatic int minor_est2(input logic [NT*COEF_W-1:0] c);
        int  acc;
        logic used;
        acc = 0;
        for (int j = 0; j < COEF_W; j++) begin
            used = 1'b0;
            for (int i = 0; i < NT; i++) used = used | c[i*COEF_W + j];
            if (used)
                for (int p = j; p < LOW_TOP; p++) acc = acc + (1 << p);
        end
        return acc;
    endfunction

    localparam int EST2     = minor_est2(COEFS);
    localparam int COMP_MAX = (COEF_W * ((1 << MAJOR_COLS) - 1) * (1 << (LOW_TOP + 1))
                               + EST2 + (1 << FRAC)) >> (FRAC + 1);
    localparam logic signed [MP_W:0] LIM_HI = (MP_W+1)'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [MP_W:0] LIM_LO = (MP_W+1)'(-(1 << (OUT_W - 1)));

    logic signed [WORD_W-1:0] word [COEF_W];
    logic signed [TERM_W-1:0] term [COEF_W];
    logic signed [MP_W-1:0]   mp_d, mp_q;
    logic [MAJ_W-1:0]         maj_d, maj_q;
    logic [NUM_W-1:0]         comp_num;
    logic [MAJ_W:0]           comp;
    logic signed [MP_W:0]     total;
    logic [OUT_W-1:0]         z_d;

    // Bit-plane words: sum the inputs whose weight has bit j set.
    always_comb begin
        for (int j = 0; j < COEF_W; j++) begin
            word[j] = '0;
            for (int i = 0; i < NT; i++)
                if (COEFS[i*COEF_W + j]) word[j] = word[j] + WORD_W'($signed(v[i*IN_W +: IN_W]));
        end
    end

    // Shift each word by its bit weight; the sign plane carries negative weight.
    for (genvar j = 0; j < COEF_W; j++) begin : g_term
        if (j == COEF_W - 1) begin : g_sign
            assign term[j] = -(TERM_W'(word[j]) <<< j);
        end else begin : g_mag
            assign term[j] = TERM_W'(word[j]) <<< j;
        end
    end

    // Exact integer sum and exact sum of the major fractional columns.
    always_comb begin
        mp_d  = '0;
        maj_d = '0;
        for (int j = 0; j < COEF_W; j++) begin
            mp_d  = mp_d + MP_W'($signed(term[j][TERM_W-1:FRAC]));
            maj_d = maj_d + MAJ_W'(term[j][FRAC-1 -: MAJOR_COLS]);
        end
    end

    // Tree register stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mp_q  <= '0;
            maj_q <= '0;
        end else if (en_tree) begin
            mp_q  <= mp_d;
            maj_q <= maj_d;
        end
    end

    // Rounded compensation bias, added to the integer part and clamped.
    always_comb begin
        comp_num = (NUM_W'(maj_q) << (LOW_TOP + 1)) + NUM_W'(EST2) + NUM_W'(1 << FRAC);
        comp     = comp_num[NUM_W-1:FRAC+1];
        total    = $signed({mp_q[MP_W-1], mp_q}) + $signed({{(MP_W-MAJ_W){1'b0}}, comp});
        if (total > LIM_HI)      z_d = LIM_HI[OUT_W-1:0];
        else if (total < LIM_LO) z_d = LIM_LO[OUT_W-1:0];
        else                     z_d = total[OUT_W-1:0];
    end

    // Output register stage, loaded only for a valid vector.
    always_ff @(posedge clk) begin
        if (!rst_n)      z <= '0;
        else if (en_out) z <= z_d;
    end

    // R4: the compensation bias stays inside its derived bound.
    a_r4_bias_bound: assert property (@(posedge clk) disable iff (!rst_n)
        32'(comp) <= COMP_MAX);

    // R7: without a load the result register holds.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_out |=> $stable(z));

endmodule

// File: rtl/dct8_da.sv
// Top of the eight-point transform: folding stage, eight compensated
// inner-product trees (even rows on mirror sums, odd rows on differences) and
// a three-stage valid pipeline. One vector per clock, latency three edges.
module dct8_da
    import dct8_pkg::*;
#(
    parameter int SAMP_W     = 9,
    parameter int OUT_W      = 12,
    parameter int MAJOR_COLS = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [NPTS*SAMP_W-1:0] in_x,
    output logic                   out_valid,
    output logic [NPTS*OUT_W-1:0]  out_z
);
    localparam int BW = SAMP_W + 1;

    logic [HALF*BW-1:0] fold_sum, fold_dif;
    logic               vld_fold, vld_tree, vld_out;

    // Valid pipeline matching the three data register stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_fold <= 1'b0;
            vld_tree <= 1'b0;
            vld_out  <= 1'b0;
        end else begin
            vld_fold <= in_valid;
            vld_tree <= vld_fold;
            vld_out  <= vld_tree;
        end
    end

    assign out_valid = vld_out;

    dct8_butterfly #(.NPTS(NPTS), .SW(SAMP_W)) u_fold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (in_valid),
        .x     (in_x),
        .sum_q (fold_sum),
        .dif_q (fold_dif)
    );

    for (genvar n = 0; n < NPTS; n++) begin : g_row
        localparam logic [HALF*COEF_W-1:0] ROW = row_coefs(n);
        logic [HALF*BW-1:0] row_in;
        if (n % 2 == 0) begin : g_even
            assign row_in = fold_sum;
        end else begin : g_odd
            assign row_in = fold_dif;
        end
        dct8_ecat #(
            .NT(HALF), .IN_W(BW), .COEF_W(COEF_W), .OUT_W(OUT_W),
            .MAJOR_COLS(MAJOR_COLS), .COEFS(ROW)
        ) u_tree (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_tree (vld_fold),
            .en_out  (vld_tree),
            .v       (row_in),
            .z       (out_z[n*OUT_W +: OUT_W])
        );
    end

    // R5: every output strobe traces back to an accepted vector three edges earlier.
    a_r5_valid_origin: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R8: the first cycle after reset carries no result.
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/tb_dct8_da.sv
// Scoreboard bench: driver tasks push each vector with its check mode, and a
// monitor pops and compares against a double-precision model on every strobe.
module tb_dct8_da;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 8;
    localparam int SW = 9;
    localparam int OW = 12;
    localparam real PI = 3.14159265358979323846;

    // check modes
    localparam int M_TOL  = 0;  // R1 (and R4 statistics)
    localparam int M_SYM  = 1;  // R3 odd rows zero
    localparam int M_ANTI = 2;  // R3 even rows zero
    localparam int M_EXT  = 3;  // R6
    localparam int M_ZERO = 4;  // R2
    localparam int M_B2B  = 5;  // R9

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [N*SW-1:0]   in_x = '0;
    logic              out_valid;
    logic [N*OW-1:0]   out_z;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  n_results = 0;
    int  n_pushed  = 0;
    real err_sum  = 0.0;
    int  err_cnt  = 0;
    bit  done     = 1'b0;

    logic [N*SW-1:0] q_vec[$];
    int              q_mode[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dct8_da dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_x      (in_x),
        .out_valid (out_valid),
        .out_z     (out_z)
    );

    function automatic real ref_z(input logic [N*SW-1:0] v, input int n);
        real acc;
        int  xi;
        acc = 0.0;
        for (int m = 0; m < N; m++) begin
            xi  = $signed(v[m*SW +: SW]);
            acc = acc + real'(xi) * $cos(real'((2*m+1)*n) * PI / 16.0);
        end
        acc = acc * 0.5;
        if (n == 0) acc = acc / $sqrt(2.0);
        return acc;
    endfunction

    function automatic int zout(input int n);
        return $signed(out_z[n*OW +: OW]);
    endfunction

    task automatic push(input logic [N*SW-1:0] v, input int mode);
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = v;
        q_vec.push_back(v);
        q_mode.push_back(mode);
        n_pushed++;
    endtask

    task automatic idle(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [N*SW-1:0] rand_vec();
        logic [N*SW-1:0] v;
        for (int m = 0; m < N; m++) v[m*SW +: SW] = SW'($urandom_range(0, 511));
        return v;
    endfunction

    // Monitor: pop the expected item and compare all eight outputs.
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            n_results++;
            n_checks++;
            if (q_vec.size() == 0) begin
                n_fail++;
                $display("FAIL R5 strobe with no vector: actual=1 expected=0");
            end else begin
                logic [N*SW-1:0] v;
                int  mode;
                bit  bad;
                v    = q_vec.pop_front();
                mode = q_mode.pop_front();
                bad  = 1'b0;
                for (int n = 0; n < N; n++) begin
                    real r;
                    int  e, a, d;
                    r = ref_z(v, n);
                    e = int'(r);
                    a = zout(n);
                    d = (a > e) ? a - e : e - a;
                    if (mode == M_TOL) begin
                        err_sum = err_sum + (real'(a) - r);
                        err_cnt++;
                    end
                    if ((mode == M_SYM && n % 2 == 1) || (mode == M_ANTI && n % 2 == 0) || mode == M_ZERO) begin
                        if (a != 0) begin
                            bad = 1'b1;
                            $display("FAIL %s n=%0d actual=%0d expected=0",
                                     (mode == M_ZERO) ? "R2" : "R3", n, a);
                        end
                    end else if (d > 2) begin
                        bad = 1'b1;
                        $display("FAIL %s n=%0d actual=%0d expected=%0d",
                                 (mode == M_EXT) ? "R6" : (mode == M_B2B) ? "R9" : "R1", n, a, e);
                    end
                end
                if (bad) n_fail++;
            end
        end
    end

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [N*SW-1:0] v;
        logic [N*OW-1:0] held;
        real mean;

        // R8: reset with junk offered on the inputs.
        in_valid = 1'b1;
        in_x     = rand_vec();
        repeat (4) @(negedge clk);
        in_valid = 1'b0;
        rst_n    = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            n_checks++;
            if (out_valid !== 1'b0 || out_z !== '0) begin
                n_fail++;
                $display("FAIL R8 after reset: actual valid=%0b z=%h expected valid=0 z=0", out_valid, out_z);
            end
        end

        // R5: exact latency of a single vector.
        v = rand_vec();
        push(v, M_TOL);
        @(negedge clk);
        in_valid = 1'b0;
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 after 1 edge: actual=%0b expected=0", out_valid);
        end
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R5 after 2 edges: actual=%0b expected=0", out_valid);
        end
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b1) begin
            n_fail++;
            $display("FAIL R5 after 3 edges: actual=%0b expected=1", out_valid);
        end
        idle(3);

        // R7: outputs hold while inputs change with in_valid low.
        held = out_z;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            in_x = rand_vec();
        end
        n_checks++;
        if (out_z !== held || out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R7 hold: actual=%h expected=%h", out_z, held);
        end

        // R2: zero vector.
        push('0, M_ZERO);
        idle(4);

        // R3: symmetric and antisymmetric vectors.
        for (int k = 0; k < 20; k++) begin
            for (int m = 0; m < N/2; m++) begin
                int s;
                s = $urandom_range(0, 510) - 255;
                v[m*SW +: SW]       = SW'(s);
                v[(N-1-m)*SW +: SW] = SW'(s);
            end
            push(v, M_SYM);
            for (int m = 0; m < N/2; m++) begin
                int s;
                s = $urandom_range(0, 510) - 255;
                v[m*SW +: SW]       = SW'(s);
                v[(N-1-m)*SW +: SW] = SW'(-s);
            end
            push(v, M_ANTI);
        end
        idle(4);

        // R6: extreme patterns.
        for (int m = 0; m < N; m++) v[m*SW +: SW] = SW'(255);
        push(v, M_EXT);
        for (int m = 0; m < N; m++) v[m*SW +: SW] = SW'(-256);
        push(v, M_EXT);
        for (int m = 0; m < N; m++) v[m*SW +: SW] = (m % 2 == 0) ? SW'(255) : SW'(-256);
        push(v, M_EXT);
        for (int m = 0; m < N; m++) v[m*SW +: SW] = (m < N/2) ? SW'(255) : SW'(-256);
        push(v, M_EXT);
        for (int m = 0; m < N; m++) v[m*SW +: SW] = (m % 4 == 0 || m % 4 == 3) ? SW'(-256) : SW'(255);
        push(v, M_EXT);
        idle(4);

        // R9: a directed back-to-back burst of ramps.
        for (int k = 0; k < 16; k++) begin
            for (int m = 0; m < N; m++) v[m*SW +: SW] = SW'((k * 37 + m * 61) % 511 - 255);
            push(v, M_B2B);
        end
        idle(5);

        // R1 / R4: a long stream of random vectors, back to back.
        for (int k = 0; k < 3000; k++) push(rand_vec(), M_TOL);
        idle(6);

        // R9: every vector came out, nothing left behind.
        n_checks++;
        if (q_vec.size() != 0 || n_results != n_pushed) begin
            n_fail++;
            $display("FAIL R9 results: actual=%0d expected=%0d", n_results, n_pushed);
        end

        // R4: mean signed error.
        mean = (err_cnt > 0) ? err_sum / real'(err_cnt) : 1.0;
        n_checks++;
        if (mean > 0.25 || mean < -0.25) begin
            n_fail++;
            $display("FAIL R4 mean error: actual=%f expected=within 0.25", mean);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule